// File: doc/BRIEF.md
# I2C EEPROM slave controller

This block is the bus-facing and storage side of a serial byte memory that answers on a two-wire I2C bus as a slave. The external master drives the clock line and makes every START and STOP; the block samples both lines with a faster system clock. It only ever pulls the data line low and otherwise leaves it released, so it can share the wire with other open-drain devices. A device select byte is checked against a fixed prefix and two strap inputs, so four of these blocks can sit on one bus.

After a write select, the master sends a two-byte word address and then any number of data bytes. The data bytes go into a 64-byte page, and the address wraps inside that page. After a read select, the block returns bytes from its current address and moves the address on by one after each byte. The master can set a new address first with a write select that it follows by a repeated START. A write-protect input fences off the upper quarter of the 15-bit address space. The storage array holds 2^MEM_AW bytes and is indexed by the low address bits, so its size can be cut down for smaller builds.

Top module: `i2c_mem_slave`

## Requirements
- R1: While reset is held, and on the first cycle after it, `sda_pull` is 0 (the data line is released).
- R2: The select byte is sent MSB first as 1010, 0, A1, A0, R/W, where A1/A0 must equal `a_sel[1:0]` and R/W=1 means read. A matching byte is acknowledged by pulling SDA low in the ninth clock. A byte that does not match gets no acknowledge, and SDA stays released for every following byte until the next START.
- R3: After a write select, the block takes a high address byte (its bit 7 is ignored) and then a low address byte, and acknowledges each. Each data byte that follows is acknowledged and stored at the current address. The storage location is the low MEM_AW bits of the 15-bit address.
- R4: During a write, the address advances by one inside its 64-byte page. After offset 63 it returns to offset 0 of the same page.
- R5: A read returns the byte at the current address and then advances the address by one. A master ACK makes the block send the next byte. A master NACK followed by STOP ends the read. A read select with no address phase starts at the address left by the previous access.
- R6: During a read, the address moves from 7FFFh to 0000h.
- R7: With `wp`=1, a data byte aimed at 6000h–7FFFh is still acknowledged but leaves the memory unchanged. Writes below 6000h still take effect.
- R8: With `wp`=0, every address from 0000h to 7FFFh can be written, including 6000h–7FFFh.
- R9: A START or STOP in the middle of a byte abandons that byte, which is not written. A START begins a new select byte, and the address counter keeps its value.
- R10: `sda_pull` changes only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level as seen on the wire (asynchronous) |
| wp | input | 1 | Write protect for addresses 6000h–7FFFh when high |
| a_sel | input | 2 | Strap value compared with the A1/A0 bits of the select byte |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |

## Verification
The hardest case to reach from the ports is a transfer broken off halfway through a data byte. This must leave both the memory and the address counter as they were. To get there, the bench sets an address, clocks in only part of a data byte, and then makes a repeated START or a STOP. It then reads the location back, both with a current-address read and with a fresh random read. Page wrap and the 7FFFh-to-0000h read wrap are reached by placing the address one or two bytes before each boundary. The protection edge is tested on both sides, at 5FFFh and at 6000h, with `wp` in each state.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  // bus-level state of the byte engine
  typedef enum logic [2:0] {
    BS_IDLE,
    BS_RX,
    BS_RX_ACK,
    BS_TX,
    BS_TX_ACK
  } bus_state_t;

  // meaning of the next received byte
  typedef enum logic [1:0] {
    RB_SEL,
    RB_AHI,
    RB_ALO,
    RB_DATA
  } rx_role_t;

  localparam logic [3:0] SEL_PREFIX = 4'b1010;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  // data edges while the clock stays high mark bus conditions
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_lvl,
  input  logic              wp,
  input  logic [1:0]        a_sel,
  input  logic [7:0]        rd_data,
  output logic              sda_pull,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              idle
);

  localparam int                HI_W      = ADDR_W - 8;
  localparam logic [3:0]        BYTE_BITS = 4'd8;
  localparam logic [3:0]        CNT_ONE   = 4'd1;
  localparam logic [PAGE_W-1:0] PAGE_ONE  = 1;
  localparam logic [ADDR_W-1:0] ADDR_ONE  = 1;
  localparam logic [ADDR_W-1:0] PROT_BASE = {2'b11, {(ADDR_W-2){1'b0}}};

  bus_state_t        state;
  rx_role_t          role;
  logic [3:0]        bit_cnt;
  logic [7:0]        shreg;
  logic              rd_mode;
  logic              m_ack;
  logic              sel_match;
  logic              wr_blocked;
  logic              tx_go;
  logic [ADDR_W-1:0] page_next;

  always_comb begin
    sel_match  = (shreg[7:1] == {SEL_PREFIX, 1'b0, a_sel});
    wr_blocked = wp && (cur_addr >= PROT_BASE);
    page_next  = {cur_addr[ADDR_W-1:PAGE_W], cur_addr[PAGE_W-1:0] + PAGE_ONE};
    tx_go      = scl_fall &&
                 (((state == BS_RX_ACK) && rd_mode && (role == RB_AHI)) ||
                  ((state == BS_TX_ACK) && m_ack));
  end

  assign idle = (state == BS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= BS_IDLE;
      role      <= RB_SEL;
      bit_cnt   <= '0;
      shreg     <= '0;
      sda_pull  <= 1'b0;
      rd_mode   <= 1'b0;
      m_ack     <= 1'b0;
      cur_addr  <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (stop_det) begin
        state    <= BS_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        state    <= BS_RX;
        role     <= RB_SEL;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else if (tx_go) begin
        // load the byte at the current address, drive its MSB
        shreg    <= rd_data;
        sda_pull <= ~rd_data[7];
        bit_cnt  <= CNT_ONE;
        cur_addr <= cur_addr + ADDR_ONE;
        state    <= BS_TX;
      end else begin
        case (state)
          BS_RX: begin
            if (scl_rise && (bit_cnt != BYTE_BITS)) begin
              shreg   <= {shreg[6:0], sda_lvl};
              bit_cnt <= bit_cnt + CNT_ONE;
            end else if (scl_fall && (bit_cnt == BYTE_BITS)) begin
              bit_cnt  <= '0;
              state    <= BS_RX_ACK;
              sda_pull <= 1'b1;
              case (role)
                RB_SEL: begin
                  if (sel_match) begin
                    rd_mode <= shreg[0];
                    role    <= RB_AHI;
                  end else begin
                    state    <= BS_IDLE;
                    sda_pull <= 1'b0;
                  end
                end
                RB_AHI: begin
                  cur_addr[ADDR_W-1:8] <= shreg[HI_W-1:0];
                  role                 <= RB_ALO;
                end
                RB_ALO: begin
                  cur_addr[7:0] <= shreg;
                  role          <= RB_DATA;
                end
                default: begin
                  mem_we    <= ~wr_blocked;
                  mem_waddr <= cur_addr[MEM_AW-1:0];
                  mem_wdata <= shreg;
                  cur_addr  <= page_next;
                end
              endcase
            end
          end
          BS_RX_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= BS_RX;
            end
          end
          BS_TX: begin
            if (scl_fall) begin
              if (bit_cnt == BYTE_BITS) begin
                sda_pull <= 1'b0;
                state    <= BS_TX_ACK;
              end else begin
                shreg    <= {shreg[6:0], 1'b0};
                sda_pull <= ~shreg[6];
                bit_cnt  <= bit_cnt + CNT_ONE;
              end
            end
          end
          BS_TX_ACK: begin
            if (scl_rise) m_ack <= ~sda_lvl;
            else if (scl_fall) state <= BS_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int PAGE_W      = 6,
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       wp,
  input  logic [1:0] a_sel,
  output logic       sda_pull
);

  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we, ctrl_idle;
  logic [MEM_AW-1:0] mem_waddr;
  logic [7:0]        mem_wdata, rd_data;
  logic [ADDR_W-1:0] cur_addr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_mem_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .MEM_AW(MEM_AW)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl),
    .wp        (wp),
    .a_sel     (a_sel),
    .rd_data   (rd_data),
    .sda_pull  (sda_pull),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .cur_addr  (cur_addr),
    .idle      (ctrl_idle)
  );

  i2c_mem_array #(.AW(MEM_AW), .DW(8)) array_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (cur_addr[MEM_AW-1:0]),
    .rdata (rd_data)
  );

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_lvl,
  input logic              sda_pull,
  input logic              in_idle,
  input logic              mem_we,
  input logic [ADDR_W-1:0] addr,
  input logic              wp
);

  localparam logic [ADDR_W-1:0] PROT_BASE = {2'b11, {(ADDR_W-2){1'b0}}};

  assert_reset_release_R1: assert property (@(posedge clk)
    rst |=> !sda_pull);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    in_idle |-> !sda_pull);

  assert_page_hold_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));

  assert_protect_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !($past(wp) && ($past(addr) >= PROT_BASE)));

  assert_scl_low_change_R10: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_lvl));

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .scl_lvl  (scl_lvl),
  .sda_pull (sda_pull),
  .in_idle  (ctrl_idle),
  .mem_we   (mem_we),
  .addr     (cur_addr),
  .wp       (wp)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb_top;

  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 6;
  localparam int         MEM_AW     = 10;
  localparam logic [7:0] SEL_W      = 8'hA4;  // 1010 0 A1=1 A0=0 W
  localparam logic [7:0] SEL_R      = 8'hA5;

  // {wp, addr[14:0], data}
  localparam logic [23:0] VEC [8] = '{
    {1'b0, 15'h0010, 8'hA5},
    {1'b0, 15'h1234, 8'h3C},
    {1'b1, 15'h5FFF, 8'h77},
    {1'b0, 15'h6000, 8'h11},
    {1'b1, 15'h6000, 8'hEE},
    {1'b0, 15'h7FFE, 8'h42},
    {1'b1, 15'h7FFE, 8'h99},
    {1'b1, 15'h2345, 8'hC3}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_pull = 1'b0;
  logic       wp = 1'b0;
  logic [1:0] a_sel = 2'b10;
  logic       sda_pull;
  logic       sda_bus;
  int         checks = 0;
  int         errors = 0;
  int         r10_viol = 0;
  bit         done = 1'b0;
  logic [7:0] model [1 << MEM_AW];

  assign sda_bus = ~(m_pull | sda_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mem_slave #(.MEM_AW(MEM_AW)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl),
    .sda_in   (sda_bus),
    .wp       (wp),
    .a_sel    (a_sel),
    .sda_pull (sda_pull)
  );

  // R10 monitor: the pull must not move while SCL stays high
  logic prev_scl = 1'b1, prev_pull = 1'b0;
  always @(negedge clk) begin
    if (!rst && scl && prev_scl && (sda_pull !== prev_pull)) r10_viol++;
    prev_scl  <= scl;
    prev_pull <= sda_pull;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_bit(input logic tx, output logic rx);
    tick(Q); m_pull = ~tx;
    tick(Q); scl = 1'b1;
    tick(Q); rx = sda_bus;
    tick(Q); scl = 1'b0;
  endtask

  task automatic bus_start;
    tick(Q); m_pull = 1'b0;
    tick(Q); scl = 1'b1;
    tick(Q); m_pull = 1'b1;
    tick(Q); scl = 1'b0;
  endtask

  task automatic bus_stop;
    tick(Q); m_pull = 1'b1;
    tick(Q); scl = 1'b1;
    tick(Q); m_pull = 1'b0;
    tick(Q);
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string req);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    check(req, {31'd0, ~r}, {31'd0, exp_ack});
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      b[i] = r;
    end
    bus_bit(~give_ack, r);
  endtask

  task automatic set_addr(input logic [14:0] a, input string req);
    bus_start;
    send_chk(SEL_W, 1'b1, req);
    send_chk({1'b1, a[14:8]}, 1'b1, req);  // bit 7 set: must be ignored (R3)
    send_chk(a[7:0], 1'b1, req);
  endtask

  task automatic write1(input logic [14:0] a, input logic [7:0] d, input logic w, input string req);
    wp = w;
    set_addr(a, req);
    send_chk(d, 1'b1, req);
    bus_stop;
    if (!(w && a >= 15'h6000)) model[a[MEM_AW-1:0]] = d;
    wp = 1'b0;
  endtask

  task automatic read_at(input logic [14:0] a, input int n, input string req);
    logic [7:0]  b;
    logic [14:0] ea;
    set_addr(a, req);
    bus_start;
    send_chk(SEL_R, 1'b1, req);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      ea = a + 15'(k);
      check(req, {24'd0, b}, {24'd0, model[ea[MEM_AW-1:0]]});
    end
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic       r;
    tick(3);
    check("R1 pull during reset", {31'd0, sda_pull}, 32'd0);
    tick(2);
    rst = 1'b0;
    tick(1);
    check("R1 pull after reset", {31'd0, sda_pull}, 32'd0);

    // R2: wrong strap bits, then wrong fixed bit
    bus_start;
    send_chk(8'hA0, 1'b0, "R2 strap mismatch");
    send_chk(8'h00, 1'b0, "R2 ignored after mismatch");
    bus_stop;
    bus_start;
    send_chk(8'hAC, 1'b0, "R2 fixed bit mismatch");
    bus_stop;

    // vector table: write then random read back
    for (int i = 0; i < 8; i++) begin
      write1(VEC[i][22:8], VEC[i][7:0], VEC[i][23], "R3/R7/R8 vector write");
      read_at(VEC[i][22:8], 1, "R3/R7/R8 vector readback");
    end

    // R4 page wrap: 4 bytes from offset 62
    set_addr(15'h013E, "R4 page addr");
    send_chk(8'h01, 1'b1, "R4 data");
    send_chk(8'h02, 1'b1, "R4 data");
    send_chk(8'h03, 1'b1, "R4 data");
    send_chk(8'h04, 1'b1, "R4 data");
    bus_stop;
    model[10'h13E] = 8'h01;
    model[10'h13F] = 8'h02;
    model[10'h100] = 8'h03;
    model[10'h101] = 8'h04;
    read_at(15'h013E, 2, "R5 sequential");
    read_at(15'h0100, 1, "R4 wrapped byte");
    // R5 current-address read continues at 0101h
    bus_start;
    send_chk(SEL_R, 1'b1, "R5 current select");
    recv_byte(1'b0, b);
    check("R5 current read", {24'd0, b}, 32'h04);
    bus_stop;

    // R6 read wrap across top of address space
    write1(15'h7FFF, 8'h5A, 1'b0, "R6 setup");
    write1(15'h0000, 8'h6B, 1'b0, "R6 setup");
    read_at(15'h7FFF, 2, "R6 wrap read");

    // R9 START mid data byte
    write1(15'h0050, 8'hD1, 1'b0, "R9 setup");
    set_addr(15'h0050, "R9 addr");
    for (int i = 0; i < 4; i++) bus_bit(1'b0, r);
    bus_start;
    send_chk(SEL_R, 1'b1, "R9 restart select");
    recv_byte(1'b0, b);
    check("R9 start abort", {24'd0, b}, 32'hD1);
    bus_stop;

    // R9 STOP mid data byte
    write1(15'h0051, 8'h3E, 1'b0, "R9 setup");
    set_addr(15'h0051, "R9 addr");
    for (int i = 0; i < 5; i++) bus_bit(1'b0, r);
    bus_stop;
    read_at(15'h0051, 1, "R9 stop abort");

    check("R10 pull moved with SCL high", r10_viol, 32'd0);
    check("R1 released at end", {31'd0, sda_pull}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule